// File: doc/BRIEF.md
# Spread-Spectrum Divider Offset Generator

This block sits beside the feedback divider of a frequency synthesizer and runs on the reference clock. Each reference cycle it produces a signed frequency-offset word. A fractional divider stage, outside this block, adds that word to its ratio. The word follows a symmetric triangle, so the synthesized clock sweeps around its nominal frequency. Its energy is spread over a band, and the peak emission at the fundamental and its harmonics drops.

Two sweep shapes are offered, each with its own deviation step:

- **Centered:** the offset swings between +D and −D.
- **Downward:** the offset swings between −D and zero, so the highest frequency reached is the nominal one.

The programmed half-period count sets the sweep rate. It is the number of reference cycles spent on each slope.

The block is also given the reference frequency and the intended sweep rate in kHz. With these it checks the configuration against the supported limits. An unsupported configuration raises a flag and holds the offset at zero. This block drives only the synthesized path; outputs that copy the reference clock directly never receive the offset.

Top module: `ssc_mod_gen`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears `ofs` to 0, `sweep_up` to 0 and `cfg_bad` to 0. The profile restarts from its start point: at the top of the triangle, about to descend.
- R2: While `en` is 0, the registered `ofs` is 0 and `sweep_up` is 0, and the profile returns to its start point. On the first enabled edge after that, the profile begins the descent again from the top.
- R3: With `spread_down`=0 (centered), the deviation D in units of 1/65536 percent is `dev_code`×8192, so each code step is 0.125%. Valid codes are 0 to 24, and the offset spans +D down to −D.
- R4: With `spread_down`=1 (downward), D is `dev_code`×16384, so each code step is 0.25%. Valid codes are 0 to 16, and the offset spans 0 down to −D; it is never positive.
- R5: Let N be `half_cnt`, S the span (2D centered, D downward), T the top value (D centered, 0 downward), c the number of enabled edges since the start point, and h = c mod 2N. Then `ofs` = T − d, where:
  - d = floor(S·h/N) when h ≤ N;
  - d = S − floor(S·(h−N)/N) otherwise.

  The slope therefore changes by the same amount per cycle, to within one unit, and it reaches each peak exactly.
- R6: `sweep_up` is 1 exactly while the profile is on its rising slope, that is, when N ≤ h < 2N.
- R7: The sweep rate `rate_khz` must lie between 30 and 130 inclusive. Any other value makes the configuration invalid.
- R8: The configuration is invalid when `rate_khz`×225 exceeds `ref_khz`, or when `ref_khz` is below 6750.
- R9: The configuration is invalid when the deviation code is above the maximum for the selected shape, or when `half_cnt` is 0.
- R10: When `en` is 1 and the configuration is invalid, `cfg_bad` is 1 on the next edge and `ofs` is held at 0. `cfg_bad` is 0 whenever `en` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Spreading enable |
| spread_down | input | 1 | 0 = centered sweep, 1 = downward sweep |
| dev_code | input | 5 | Deviation code |
| half_cnt | input | 16 | Reference cycles per slope (N) |
| rate_khz | input | 8 | Intended sweep rate in kHz |
| ref_khz | input | 18 | Reference frequency in kHz |
| ofs | output | 20 | Signed offset word, 1/65536 percent per unit |
| sweep_up | output | 1 | 1 while the profile rises |
| cfg_bad | output | 1 | Configuration unsupported while enabled |

## Verification
All three outputs are registered. Each one reflects the inputs present before a rising edge at that same edge, so every result is due exactly one cycle after its stimulus. The bench changes inputs 1 ns after a rising edge and samples the outputs 1 ns after the following edge. For profile sweeps, the bench counts enabled edges from the start point and evaluates the closed-form R5 expression at each sampled edge. Limit checks insert one disabled cycle before each case, so that the enabled edge that follows is always edge c=1 of a fresh profile.

// File: rtl/ssc_mod_gen.sv
module ssc_mod_gen #(
  parameter int REF_W     = 18,
  parameter int RATE_W    = 8,
  parameter int CODE_W    = 5,
  parameter int CNT_W     = 16,
  parameter int OFS_W     = 20,
  parameter int CTR_MAX   = 24,
  parameter int DN_MAX    = 16,
  parameter int CTR_LSB   = 8192,
  parameter int DN_LSB    = 16384,
  parameter int RATE_MIN  = 30,
  parameter int RATE_MAX  = 130,
  parameter int REF_MIN   = 6750,
  parameter int REF_RATIO = 225
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    spread_down,
  input  logic [CODE_W-1:0]       dev_code,
  input  logic [CNT_W-1:0]        half_cnt,
  input  logic [RATE_W-1:0]       rate_khz,
  input  logic [REF_W-1:0]        ref_khz,
  output logic signed [OFS_W-1:0] ofs,
  output logic                    sweep_up,
  output logic                    cfg_bad
);
  localparam int DW = (OFS_W > CNT_W) ? OFS_W : CNT_W;

  logic code_ok, rate_ok, ref_ok, ratio_ok, cnt_ok, viol, go;
  logic [31:0] rate_x;
  logic [OFS_W-1:0] dev, span, top, delta, d, d_n;
  logic [DW-1:0] div, q, r, err, err_n;
  logic [DW:0] e2;
  logic carry, last;
  logic [CNT_W-1:0] k, k_n;

  assign code_ok  = spread_down ? (dev_code <= CODE_W'(DN_MAX)) : (dev_code <= CODE_W'(CTR_MAX));
  assign rate_ok  = (rate_khz >= RATE_W'(RATE_MIN)) && (rate_khz <= RATE_W'(RATE_MAX));
  assign ref_ok   = ref_khz >= REF_W'(REF_MIN);
  assign rate_x   = 32'(rate_khz) * 32'(REF_RATIO);
  assign ratio_ok = rate_x <= 32'(ref_khz);
  assign cnt_ok   = half_cnt != '0;
  assign viol     = !(code_ok && rate_ok && ref_ok && ratio_ok && cnt_ok);
  assign go       = en && !viol;

  assign dev  = spread_down ? OFS_W'(dev_code) * OFS_W'(DN_LSB) : OFS_W'(dev_code) * OFS_W'(CTR_LSB);
  assign span = spread_down ? dev : (dev << 1);
  assign top  = spread_down ? '0 : dev;

  assign div   = cnt_ok ? DW'(half_cnt) : DW'(1);
  assign q     = DW'(span) / div;
  assign r     = DW'(span) % div;
  assign e2    = {1'b0, err} + {1'b0, r};
  assign carry = e2 >= {1'b0, div};
  assign err_n = carry ? DW'(e2 - {1'b0, div}) : DW'(e2);
  assign delta = OFS_W'(q) + OFS_W'(carry);
  assign d_n   = sweep_up ? (d - delta) : (d + delta);
  assign k_n   = k + CNT_W'(1);
  assign last  = k_n == half_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      d        <= '0;
      k        <= '0;
      err      <= '0;
      sweep_up <= 1'b0;
      ofs      <= '0;
      cfg_bad  <= 1'b0;
    end else begin
      cfg_bad <= en && viol;
      if (!go) begin
        d        <= '0;
        k        <= '0;
        err      <= '0;
        sweep_up <= 1'b0;
        ofs      <= '0;
      end else begin
        d   <= d_n;
        ofs <= top - d_n;
        if (last) begin
          k        <= '0;
          err      <= '0;
          sweep_up <= !sweep_up;
        end else begin
          k   <= k_n;
          err <= err_n;
        end
      end
    end
  end
endmodule

// File: rtl/ssc_mod_gen_chk.sv
module ssc_mod_gen_chk #(
  parameter int CODE_W = 5,
  parameter int CNT_W  = 16,
  parameter int OFS_W  = 20
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic                    spread_down,
  input logic [CODE_W-1:0]       dev_code,
  input logic [CNT_W-1:0]        half_cnt,
  input logic signed [OFS_W-1:0] ofs,
  input logic                    sweep_up,
  input logic                    cfg_bad
);
  a_r10_bad_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |-> (ofs == '0));

  a_r10_flag_needs_en: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |-> $past(en));

  a_r2_off_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (ofs == '0 && !sweep_up));

  a_r4_down_nonpos: assert property (@(posedge clk) disable iff (rst)
    $past(spread_down) |-> (ofs <= 0));

  a_r6_rise_monotone: assert property (@(posedge clk) disable iff (rst)
    (sweep_up && $past(sweep_up) && $stable(dev_code) && $stable(spread_down) && $stable(half_cnt))
      |-> (ofs >= $past(ofs)));
endmodule

bind ssc_mod_gen ssc_mod_gen_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .spread_down(spread_down), .dev_code(dev_code),
  .half_cnt(half_cnt), .ofs(ofs), .sweep_up(sweep_up), .cfg_bad(cfg_bad)
);

// File: tb/ssc_mod_gen_tb_top.sv
module ssc_mod_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic spread_down = 1'b0;
  logic [4:0] dev_code = '0;
  logic [15:0] half_cnt = 16'd4;
  logic [7:0] rate_khz = 8'd100;
  logic [17:0] ref_khz = 18'd24000;
  logic signed [19:0] ofs;
  logic sweep_up, cfg_bad;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ssc_mod_gen dut_i (
    .clk(clk), .rst(rst), .en(en), .spread_down(spread_down), .dev_code(dev_code),
    .half_cnt(half_cnt), .rate_khz(rate_khz), .ref_khz(ref_khz),
    .ofs(ofs), .sweep_up(sweep_up), .cfg_bad(cfg_bad)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_ofs(input bit sd, input int code, input int n, input int c);
    longint dv, span, top, d;
    int h;
    dv   = sd ? longint'(code) * 16384 : longint'(code) * 8192;
    span = sd ? dv : 2 * dv;
    top  = sd ? 0 : dv;
    h    = c % (2 * n);
    if (h <= n) d = (span * h) / n;
    else d = span - (span * (h - n)) / n;
    return top - d;
  endfunction

  function automatic bit exp_up(input int n, input int c);
    return (c % (2 * n)) >= n;
  endfunction

  task automatic run_profile(input bit sd, input int code, input int n);
    en = 1'b0;
    tick();
    spread_down = sd;
    dev_code = 5'(code);
    half_cnt = 16'(n);
    rate_khz = 8'd100;
    ref_khz = 18'd24000;
    en = 1'b1;
    for (int c = 1; c <= 4 * n + 1; c++) begin
      tick();
      if (sd) chk(longint'(ofs) == exp_ofs(sd, code, n, c), "R4 R5 down profile", longint'(ofs), exp_ofs(sd, code, n, c));
      else chk(longint'(ofs) == exp_ofs(sd, code, n, c), "R3 R5 center profile", longint'(ofs), exp_ofs(sd, code, n, c));
      chk(sweep_up == exp_up(n, c), "R6 slope flag", longint'(sweep_up), longint'(exp_up(n, c)));
    end
  endtask

  task automatic try_cfg(input bit sd, input int code, input int n, input int rate, input int refk,
                         input bit exp_bad, input string req);
    en = 1'b0;
    tick();
    spread_down = sd;
    dev_code = 5'(code);
    half_cnt = 16'(n);
    rate_khz = 8'(rate);
    ref_khz = 18'(refk);
    en = 1'b1;
    tick();
    chk(cfg_bad == exp_bad, req, longint'(cfg_bad), longint'(exp_bad));
    if (exp_bad) chk(ofs == '0, {req, " offset held"}, longint'(ofs), 0);
    else chk(longint'(ofs) == exp_ofs(sd, code, n, 1), {req, " first step"}, longint'(ofs), exp_ofs(sd, code, n, 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick();
    tick();
    chk(ofs == '0, "R1 reset offset", longint'(ofs), 0);
    chk(sweep_up == 1'b0, "R1 reset slope", longint'(sweep_up), 0);
    chk(cfg_bad == 1'b0, "R1 reset flag", longint'(cfg_bad), 0);
    rst = 1'b0;

    for (int n = 1; n <= 7; n++) begin
      if (n == 4 || n == 6) continue;
      for (int code = 0; code <= 24; code++) run_profile(1'b0, code, n);
      for (int code = 0; code <= 16; code++) run_profile(1'b1, code, n);
    end

    run_profile(1'b0, 10, 5);
    for (int i = 0; i < 3; i++) tick();
    rst = 1'b1;
    tick();
    chk(ofs == '0, "R1 mid-run reset offset", longint'(ofs), 0);
    chk(sweep_up == 1'b0, "R1 mid-run reset slope", longint'(sweep_up), 0);
    rst = 1'b0;
    tick();
    chk(longint'(ofs) == exp_ofs(1'b0, 10, 5, 1), "R1 restart from top", longint'(ofs), exp_ofs(1'b0, 10, 5, 1));

    spread_down = 1'b0; dev_code = 5'd8; half_cnt = 16'd6; rate_khz = 8'd100; ref_khz = 18'd24000;
    en = 1'b1;
    for (int i = 0; i < 8; i++) tick();
    en = 1'b0;
    tick();
    chk(ofs == '0, "R2 disable zero", longint'(ofs), 0);
    chk(sweep_up == 1'b0, "R2 disable slope", longint'(sweep_up), 0);
    tick();
    chk(ofs == '0, "R2 still zero", longint'(ofs), 0);
    en = 1'b1;
    tick();
    chk(longint'(ofs) == exp_ofs(1'b0, 8, 6, 1), "R2 re-enable restart", longint'(ofs), exp_ofs(1'b0, 8, 6, 1));

    try_cfg(1'b0, 4, 5, 29, 24000, 1'b1, "R7 rate below floor");
    try_cfg(1'b0, 4, 5, 30, 24000, 1'b0, "R7 rate at floor");
    try_cfg(1'b0, 4, 5, 130, 29250, 1'b0, "R7 rate at ceiling");
    try_cfg(1'b0, 4, 5, 131, 60000, 1'b1, "R7 rate above ceiling");
    try_cfg(1'b1, 4, 5, 100, 22500, 1'b0, "R8 ratio at limit");
    try_cfg(1'b1, 4, 5, 100, 22499, 1'b1, "R8 ratio exceeded");
    try_cfg(1'b0, 4, 5, 30, 6750, 1'b0, "R8 reference at minimum");
    try_cfg(1'b0, 4, 5, 30, 6749, 1'b1, "R8 reference below minimum");
    try_cfg(1'b0, 24, 3, 100, 24000, 1'b0, "R9 center top code");
    try_cfg(1'b0, 25, 3, 100, 24000, 1'b1, "R9 center code too large");
    try_cfg(1'b1, 16, 3, 100, 24000, 1'b0, "R9 down top code");
    try_cfg(1'b1, 17, 3, 100, 24000, 1'b1, "R9 down code too large");
    try_cfg(1'b0, 5, 0, 100, 24000, 1'b1, "R9 zero half count");
    try_cfg(1'b1, 3, 2, 200, 1000, 1'b1, "R10 all limits broken");

    en = 1'b0;
    rate_khz = 8'd200;
    tick();
    tick();
    chk(cfg_bad == 1'b0, "R10 flag needs enable", longint'(cfg_bad), 0);
    chk(ofs == '0, "R10 disabled bad config", longint'(ofs), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule